// File: doc/BRIEF.md
# Flash Command Unlock Decoder

This block sits between a host write port and a flash operation sequencer. It turns a stream of bus writes into single-cycle operation requests. Each write is one valid pulse that carries an address and a data word. A write only counts when it forms part of a recognised unlock pattern. Two key writes, data AA at word address 5555 and then data 55 at 2AAA, must come before any command. For the long operations, a second key pair follows an extend code.

Only the low 16 address bits and the low 8 data bits take part in matching. A request carries the full address and data of the write that completed it. A few codes act in one cycle with no key prefix: suspend, resume and identification exit. A six-write sequence can also enter a bypass state. After that, every write becomes a program request until reset, including writes that hold erase or suspend codes. While the sequencer reports busy, all writes are ignored.

Top module: `unlock_seq_decoder`

## Requirements
- R1: After reset, no request output is high and `bypass_active` is low. Asserting reset also clears bypass and any suspend state.
- R2: The write sequence (AA@5555, 55@2AAA, A0@5555, then any address A with data D) produces one `req_program` with `req_addr`=A and `req_data`=D.
- R3: The sequence (AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, 10@5555) produces one `req_chip_erase`.
- R4: The same five-write lead-in followed by data 30 at any address A produces `req_sector_erase`. Followed by data 40 at A, it produces `req_sector_lock`. In both cases `req_addr`=A.
- R5: Data 90@5555 as the third write after the key pair produces `req_id_entry`. Data F0@5555 as the third write after the key pair produces `req_id_exit`. A lone F0 at any address, written while no sequence is open, also produces `req_id_exit`.
- R6: Data B0 at any address, written while no sequence is open, produces `req_suspend` and records a suspended state. Data 30 at address A, written while suspended and with no sequence open, produces `req_resume` with `req_addr`=A and ends the suspended state. Data 30 written while not suspended produces nothing.
- R7: A write that does not match the next expected step of an open sequence drops the decoder to idle and produces no request.
- R8: Data bits 15..8 play no part in matching; 0x12AA matches as AA.
- R9: Address bits above bit 15 play no part in matching key addresses.
- R10: The sequence (AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, A0@5555) sets `bypass_active`. From then on every accepted write yields `req_program` with its own address and data, whatever its data. Only reset clears bypass.
- R11: A write presented while `busy` is high produces no request and leaves the sequence state unchanged.
- R12: Every request is registered. It is high for exactly the one cycle after the accepted write, and at most one request is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | One-cycle write pulse |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | DATA_W | Write data |
| busy | input | 1 | Sequencer program in progress; writes ignored |
| req_program | output | 1 | Program request |
| req_chip_erase | output | 1 | Whole-array erase request |
| req_sector_erase | output | 1 | Sector erase request |
| req_sector_lock | output | 1 | Sector write-lock request |
| req_suspend | output | 1 | Erase suspend request |
| req_resume | output | 1 | Erase resume request |
| req_id_entry | output | 1 | Identification mode entry request |
| req_id_exit | output | 1 | Identification mode exit request |
| req_addr | output | ADDR_W | Address of the write that completed the request |
| req_data | output | DATA_W | Data of the write that completed the request |
| bypass_active | output | 1 | Single-write program mode is on |

## Verification
The assertions assume that each write is a clean single-cycle pulse, and that `busy` is steady around it as a level from the sequencer. The bench drives every input at the falling edge, one write or idle slot per cycle. It raises `busy` only as a level for a single slot. It never pulses `wr_valid` during reset, so no write can straddle the reset release. Request outputs are compared against a behavioural model on every cycle.

// File: rtl/unlock_seq_decoder.sv
module unlock_seq_decoder #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  output logic              req_program,
  output logic              req_chip_erase,
  output logic              req_sector_erase,
  output logic              req_sector_lock,
  output logic              req_suspend,
  output logic              req_resume,
  output logic              req_id_entry,
  output logic              req_id_exit,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data,
  output logic              bypass_active
);

  localparam int NREQ = 8;
  localparam int PGM = 0, CHP = 1, SEC = 2, LCK = 3, SUS = 4, RES = 5, IDN = 6, IDX = 7;

  typedef enum logic [2:0] {IDLE, KEY1, KEY2, PROG, EXT1, EXT2, EXT3} st_t;

  st_t st, st_nx;
  logic [NREQ-1:0] req, req_nx;
  logic suspended, susp_nx, byp_nx;

  wire       take  = wr_valid & ~busy;
  wire [7:0] code  = wr_data[7:0];
  wire       at_k1 = wr_addr[15:0] == 16'h5555;
  wire       at_k2 = wr_addr[15:0] == 16'h2AAA;

  always_comb begin
    st_nx   = st;
    req_nx  = '0;
    susp_nx = suspended;
    byp_nx  = bypass_active;
    if (take) begin
      if (bypass_active) begin
        req_nx[PGM] = 1'b1;
      end else begin
        st_nx = IDLE;
        case (st)
          IDLE:
            if (code == 8'hAA && at_k1) st_nx = KEY1;
            else if (code == 8'hB0) begin req_nx[SUS] = 1'b1; susp_nx = 1'b1; end
            else if (code == 8'h30 && suspended) begin req_nx[RES] = 1'b1; susp_nx = 1'b0; end
            else if (code == 8'hF0) req_nx[IDX] = 1'b1;
          KEY1: if (code == 8'h55 && at_k2) st_nx = KEY2;
          KEY2:
            if (at_k1) begin
              case (code)
                8'hA0: st_nx = PROG;
                8'h80: st_nx = EXT1;
                8'h90: req_nx[IDN] = 1'b1;
                8'hF0: req_nx[IDX] = 1'b1;
                default: ;
              endcase
            end
          PROG: req_nx[PGM] = 1'b1;
          EXT1: if (code == 8'hAA && at_k1) st_nx = EXT2;
          EXT2: if (code == 8'h55 && at_k2) st_nx = EXT3;
          EXT3:
            if (code == 8'h10 && at_k1) req_nx[CHP] = 1'b1;
            else if (code == 8'h30) req_nx[SEC] = 1'b1;
            else if (code == 8'h40) req_nx[LCK] = 1'b1;
            else if (code == 8'hA0 && at_k1) byp_nx = 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st            <= IDLE;
      req           <= '0;
      suspended     <= 1'b0;
      bypass_active <= 1'b0;
      req_addr      <= '0;
      req_data      <= '0;
    end else begin
      st            <= st_nx;
      req           <= req_nx;
      suspended     <= susp_nx;
      bypass_active <= byp_nx;
      if (take) begin
        req_addr <= wr_addr;
        req_data <= wr_data;
      end
    end
  end

  assign req_program      = req[PGM];
  assign req_chip_erase   = req[CHP];
  assign req_sector_erase = req[SEC];
  assign req_sector_lock  = req[LCK];
  assign req_suspend      = req[SUS];
  assign req_resume       = req[RES];
  assign req_id_entry     = req[IDN];
  assign req_id_exit      = req[IDX];

  assert_one_request_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_program, req_chip_erase, req_sector_erase, req_sector_lock,
              req_suspend, req_resume, req_id_entry, req_id_exit}));

  assert_request_follows_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_program || req_chip_erase || req_sector_erase || req_sector_lock ||
     req_suspend || req_resume || req_id_entry || req_id_exit) |-> $past(wr_valid && !busy));

  assert_busy_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && busy) |=> !(req_program || req_chip_erase || req_sector_erase ||
      req_sector_lock || req_suspend || req_resume || req_id_entry || req_id_exit));

  assert_bypass_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_active |=> bypass_active);

  assert_bypass_programs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass_active && wr_valid && !busy) |=> req_program);

  assert_resume_needs_suspend_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_resume |-> $past(suspended));

endmodule

// File: tb/test_unlock_seq_decoder.sv
module test_unlock_seq_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [19:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        busy = 1'b0;
  logic req_program, req_chip_erase, req_sector_erase, req_sector_lock;
  logic req_suspend, req_resume, req_id_entry, req_id_exit, bypass_active;
  logic [19:0] req_addr;
  logic [15:0] req_data;

  always #4 clk = ~clk;

  unlock_seq_decoder i_unlock_seq_decoder (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .req_program(req_program), .req_chip_erase(req_chip_erase),
    .req_sector_erase(req_sector_erase), .req_sector_lock(req_sector_lock),
    .req_suspend(req_suspend), .req_resume(req_resume), .req_id_entry(req_id_entry),
    .req_id_exit(req_id_exit), .req_addr(req_addr), .req_data(req_data),
    .bypass_active(bypass_active));

  // expected request bits: 1 prog, 2 chip, 4 sector, 8 lock, 16 susp, 32 resume, 64 id in, 128 id out
  int checks = 0, fails = 0;
  string tag = "R1";
  int stage = 0;
  bit m_byp = 0, m_susp = 0, e_byp = 0;
  logic [7:0]  e_req = '0;
  logic [19:0] e_addr = '0;
  logic [15:0] e_data = '0;
  bit done = 0;

  task automatic compare();
    logic [7:0] got;
    got = {req_id_exit, req_id_entry, req_resume, req_suspend,
           req_sector_lock, req_sector_erase, req_chip_erase, req_program};
    checks++;
    if (got !== e_req || bypass_active !== e_byp ||
        (e_req != 0 && (req_addr !== e_addr || req_data !== e_data))) begin
      fails++;
      $display("FAIL %s/R12: req=%b byp=%b addr=%h data=%h expected req=%b byp=%b addr=%h data=%h",
               tag, got, bypass_active, req_addr, req_data, e_req, e_byp, e_addr, e_data);
    end
  endtask

  task automatic model(input bit v, input logic [19:0] a, input logic [15:0] d, input bit b);
    logic [7:0] c;
    bit k1, k2;
    c = d[7:0]; k1 = a[15:0] == 16'h5555; k2 = a[15:0] == 16'h2AAA;
    e_req = 0;
    e_byp = m_byp;
    if (!v || b) return;
    e_addr = a; e_data = d;
    if (m_byp) begin e_req = 1; return; end
    case (stage)
      0: if (c == 8'hAA && k1) stage = 1;
         else if (c == 8'hB0) begin e_req = 16; m_susp = 1; end
         else if (c == 8'h30 && m_susp) begin e_req = 32; m_susp = 0; end
         else if (c == 8'hF0) e_req = 128;
      1: stage = (c == 8'h55 && k2) ? 2 : 0;
      2: begin
           stage = 0;
           if (k1 && c == 8'hA0) stage = 3;
           else if (k1 && c == 8'h80) stage = 4;
           else if (k1 && c == 8'h90) e_req = 64;
           else if (k1 && c == 8'hF0) e_req = 128;
         end
      3: begin e_req = 1; stage = 0; end
      4: stage = (c == 8'hAA && k1) ? 5 : 0;
      5: stage = (c == 8'h55 && k2) ? 6 : 0;
      default: begin
           stage = 0;
           if (c == 8'h10 && k1) e_req = 2;
           else if (c == 8'h30) e_req = 4;
           else if (c == 8'h40) e_req = 8;
           else if (c == 8'hA0 && k1) m_byp = 1;
         end
    endcase
    e_byp = m_byp;
  endtask

  task automatic step(input bit v, input logic [19:0] a, input logic [15:0] d, input bit b);
    @(negedge clk);
    compare();
    model(v, a, d, b);
    wr_valid = v; wr_addr = a; wr_data = d; busy = b;
  endtask

  task automatic wr(input logic [19:0] a, input logic [15:0] d);
    step(1'b1, a, d, 1'b0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, '0, '0, 1'b0);
  endtask

  task automatic keys();
    wr(20'h05555, 16'h00AA); wr(20'h02AAA, 16'h0055);
  endtask

  task automatic ext_lead();
    keys(); wr(20'h05555, 16'h0080); keys();
  endtask

  task automatic do_reset();
    tag = "R1";
    @(negedge clk);
    rst_n = 1'b0; wr_valid = 0; busy = 0;
    stage = 0; m_byp = 0; m_susp = 0; e_req = 0; e_byp = 0;
    for (int i = 0; i < 3; i++) begin @(negedge clk); compare(); end
    rst_n = 1'b1;
    idle(2);
  endtask

  initial begin
    do_reset();
    tag = "R2";  keys(); wr(20'h05555, 16'h00A0); wr(20'h34567, 16'hBEEF); idle(3);
    tag = "R3";  ext_lead(); wr(20'h05555, 16'h0010); idle(2);
    tag = "R4";  ext_lead(); wr(20'h41234, 16'h0030); idle(2);
    ext_lead(); wr(20'h80000, 16'h0040); idle(2);
    ext_lead(); wr(20'h05555, 16'h0030); idle(2);
    tag = "R5";  keys(); wr(20'h05555, 16'h0090); idle(2);
    keys(); wr(20'h05555, 16'h00F0); idle(1);
    wr(20'h71111, 16'h00F0); idle(2);
    tag = "R6";  wr(20'hC0000, 16'h0030); idle(1);
    wr(20'hF0F0F, 16'h00B0); idle(1);
    wr(20'hC0000, 16'h0030); idle(1);
    wr(20'h40000, 16'h0030); idle(2);
    tag = "R7";  wr(20'h05555, 16'h00AA); wr(20'h01234, 16'h0055);
    wr(20'h05555, 16'h00A0); wr(20'h00100, 16'h0012); idle(1);
    keys(); wr(20'h05554, 16'h00A0); wr(20'h00200, 16'h0013); idle(1);
    ext_lead(); wr(20'h05555, 16'h0077); wr(20'h00300, 16'h0030); idle(2);
    tag = "R8";  wr(20'h05555, 16'h12AA); wr(20'h02AAA, 16'hFF55);
    wr(20'h05555, 16'h33A0); wr(20'h01000, 16'hA5C3); idle(2);
    tag = "R9";  wr(20'hF5555, 16'h00AA); wr(20'h92AAA, 16'h0055);
    wr(20'hA5555, 16'h0090); idle(2);
    tag = "R11"; wr(20'h05555, 16'h00AA); step(1'b1, 20'h00000, 16'h0077, 1'b1);
    wr(20'h02AAA, 16'h0055); step(1'b1, 20'h05555, 16'h00B0, 1'b1);
    wr(20'h05555, 16'h00A0); wr(20'h02222, 16'h1234); idle(2);
    tag = "R12"; keys(); wr(20'h05555, 16'h00A0); wr(20'h0ABCD, 16'h4321); idle(4);
    tag = "R10"; ext_lead(); wr(20'h05555, 16'h00A0); idle(2);
    wr(20'h00010, 16'h00B0); wr(20'h00020, 16'h0030); wr(20'h05555, 16'h00AA);
    wr(20'h02AAA, 16'h0055); wr(20'h05555, 16'h0080); wr(20'h00030, 16'h00F0);
    step(1'b1, 20'h00040, 16'h0099, 1'b1); idle(3);
    do_reset();
    tag = "R10"; wr(20'h00050, 16'h00B0); idle(2);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule